// File: doc/BRIEF.md
# ARINC 429 Parallel-Load Serial Transmitter

This block turns two 16-bit host writes into one 32-bit ARINC 429 serial word. It sends the word one bit per transmit clock and follows each word with a fixed null gap. The host writes the two halves over a 16-bit bus. A select bit chooses the half: select high carries the half that goes out first, and select low carries the upper half. The upper-half write marks the staging buffer full and drops the ready flag. Both halves sit in a staging buffer until the serializer can take them. The host can therefore prepare the next word while the current one is still on the line.

On the line side the block has two return-to-zero enables, one for the high level and one for the low level, meant for an external three-level driver. It also has an NRZ copy of the bit stream and an active-low sync strobe that marks the eighth bit. A parity-enable input selects what goes into bit 32: an odd-parity bit over the whole word, or the top data bit of the upper half. All logic, including the write strobe and select, runs synchronously to the transmit clock.

Top module: `arinc_word_tx`

## Requirements
- R1: The half written with hostSel=1 gives serial bits 1..16, with bit 1 taken from hostData[0]. The half written with hostSel=0 gives bits 17..31 from hostData[0..14], and also bit 32 from hostData[15] when parity is off. Bit 1 is sent first.
- R2: A write is taken on the first rising clock edge at which writeN is sampled high after having been sampled low. hostData and hostSel are captured at that same edge.
- R3: readyOut is high while the staging buffer is empty. It goes low in the cycle after an accepted hostSel=0 write. A hostSel=1 write alone leaves it high.
- R4: Between two back-to-back words the line is null, with both enables low, for exactly four bit periods.
- R5: If the buffer is full when the fourth gap bit period ends, the buffer moves into the serializer at that edge. readyOut goes high in the same period in which bit 1 appears on the line.
- R6: If the fourth gap bit has already passed when the upper half is captured at edge E, the word moves at edge E+1. Bit 1 is then on the line in the period that follows E+1.
- R7: If parityEn is high at the move, bit 32 is set so that the 32-bit word holds an odd number of ones. If parityEn is low, bit 32 is hostData[15] of the hostSel=0 half.
- R8: An active-low asynchronous reset clears the buffer, the serializer and the sequencer, and abandons any word in flight. After reset, readyOut is high and the line stays null until a complete word has been loaded.
- R9: During each data bit, lineHi (for a 1) or lineLo (for a 0) is high only while clk is high. Both enables are low while clk is low, and the two are never high together.
- R10: nrzData equals the current bit for the whole bit period and is low during gaps and idle.
- R11: syncN is low only during the clk-low half of bit 8 of each word.
- R12: A hostSel=0 write is accepted as the upper half even when no hostSel=1 write came before it; the lower half then keeps its current contents. Any write made while readyOut is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one bit per period |
| rstN | input | 1 | Asynchronous active-low reset |
| hostData | input | 16 | Half-word write data |
| hostSel | input | 1 | 1 = half sent first (bits 1..16), 0 = upper half (bits 17..32) |
| writeN | input | 1 | Active-low write strobe, taken on its rising edge |
| parityEn | input | 1 | 1 = bit 32 is odd parity, 0 = bit 32 is hostData[15] of the upper half |
| readyOut | output | 1 | High while the staging buffer is empty |
| lineHi | output | 1 | Return-to-zero high-level enable |
| lineLo | output | 1 | Return-to-zero low-level enable |
| nrzData | output | 1 | NRZ copy of the serial bits |
| syncN | output | 1 | Active-low strobe in the low half of bit 8 |

## Verification
Two functions can land on the same edge: the last gap bit of one word ending, and the handoff of a buffer that has just filled. The bench provokes this by loading the next word while the current one is still shifting out. It then judges the result from the recorded gap length, which must be exactly four nulls. It also checks that readyOut rises in the very sample where bit 1 appears, while it was low in the sample just before. The bench also makes a write while readyOut is low, which coincides with the pending handoff. It checks that the next word comes out with its lower half unchanged.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
  // strobes from the sequencer to the datapath, valid for one clock
  typedef struct packed {
    logic loadFirst;   // capture the half sent first
    logic loadSecond;  // capture the upper half
    logic transfer;    // move the staging buffer into the serializer
    logic shift;       // advance the serializer by one bit
  } txStrobe_t;
endpackage

// File: rtl/arinc_tx_ctrl.sv
module arinc_tx_ctrl
  import arinc_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int GAP_BITS = 4,
  localparam int POS_W = $clog2(WORD_W + GAP_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             writeN,
  input  logic             hostSel,
  output txStrobe_t        strobe,
  output logic             bufFull,
  output logic             dataPhase,
  output logic [POS_W-1:0] bitPos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W + GAP_BITS - 1);
  localparam logic [POS_W-1:0] WORD_END = POS_W'(WORD_W);

  logic writeQ;
  logic accept;
  logic lastGap;

  // previous sample of the strobe, for the rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) writeQ <= 1'b1;
    else       writeQ <= writeN;
  end

  assign accept    = writeN & ~writeQ & ~bufFull;
  assign lastGap   = (bitPos == LAST_POS);
  assign dataPhase = (bitPos < WORD_END);

  always_comb begin
    strobe.loadFirst  = accept & hostSel;
    strobe.loadSecond = accept & ~hostSel;
    strobe.transfer   = lastGap & bufFull;
    strobe.shift      = dataPhase;
  end

  // position: 0..WORD_W-1 data bits, then the gap; it waits on the last gap bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= LAST_POS;
    end else if (lastGap) begin
      if (bufFull) bitPos <= '0;
    end else begin
      bitPos <= bitPos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  bufFull <= 1'b0;
    else if (strobe.transfer)   bufFull <= 1'b0;
    else if (strobe.loadSecond) bufFull <= 1'b1;
  end
endmodule

// File: rtl/arinc_tx_path.sv
module arinc_tx_path
  import arinc_tx_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] hostData,
  input  logic              parityEn,
  input  txStrobe_t         strobe,
  output logic              txBit
);
  logic [WORD_W-1:0] bufReg;
  logic [WORD_W-1:0] shiftReg;
  logic              topBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg <= '0;
    end else begin
      if (strobe.loadFirst)  bufReg[HALF_W-1:0]      <= hostData;
      if (strobe.loadSecond) bufReg[WORD_W-1:HALF_W] <= hostData;
    end
  end

  // odd parity over the lower 31 bits, or the stored top data bit
  assign topBit = parityEn ? ~^bufReg[WORD_W-2:0] : bufReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.transfer) shiftReg <= {topBit, bufReg[WORD_W-2:0]};
    else if (strobe.shift)    shiftReg <= {1'b0, shiftReg[WORD_W-1:1]};
  end

  assign txBit = shiftReg[0];
endmodule

// File: rtl/arinc_word_tx.sv
module arinc_word_tx
  import arinc_tx_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int GAP_BITS = 4,
  parameter int SYNC_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] hostData,
  input  logic              hostSel,
  input  logic              writeN,
  input  logic              parityEn,
  output logic              readyOut,
  output logic              lineHi,
  output logic              lineLo,
  output logic              nrzData,
  output logic              syncN
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int POS_W = $clog2(WORD_W + GAP_BITS);
  localparam logic [POS_W-1:0] SYNC_POS = POS_W'(SYNC_BIT - 1);

  txStrobe_t        strobe;
  logic             bufFull;
  logic             dataPhase;
  logic [POS_W-1:0] bitPos;
  logic             txBit;

  arinc_tx_ctrl #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .writeN(writeN), .hostSel(hostSel),
    .strobe(strobe), .bufFull(bufFull), .dataPhase(dataPhase), .bitPos(bitPos)
  );

  arinc_tx_path #(.HALF_W(HALF_W)) uPath (
    .clk(clk), .rstN(rstN), .hostData(hostData), .parityEn(parityEn),
    .strobe(strobe), .txBit(txBit)
  );

  assign readyOut = ~bufFull;
  assign nrzData  = dataPhase & txBit;
  // return to zero: drive only in the clock-high half of each data bit
  assign lineHi   = dataPhase & txBit & clk;
  assign lineLo   = dataPhase & ~txBit & clk;
  assign syncN    = ~(dataPhase & (bitPos == SYNC_POS) & ~clk);
endmodule

// File: rtl/arinc_word_chk.sv
module arinc_word_chk #(
  parameter int WORD_W = 32,
  parameter int GAP_BITS = 4,
  parameter int SYNC_BIT = 8,
  localparam int POS_W = $clog2(WORD_W + GAP_BITS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             writeN,
  input logic             hostSel,
  input logic             readyOut,
  input logic             lineHi,
  input logic             lineLo,
  input logic             nrzData,
  input logic             syncN,
  input logic [POS_W-1:0] bitPos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W + GAP_BITS - 1);
  localparam logic [POS_W-1:0] WORD_END = POS_W'(WORD_W);
  localparam logic [POS_W-1:0] SYNC_POS = POS_W'(SYNC_BIT - 1);

  // R3
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(writeN) && !hostSel && readyOut) |=> !readyOut);

  // R5
  handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitPos == LAST_POS && !readyOut) |=> (readyOut && bitPos == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitPos == LAST_POS && readyOut) |=> bitPos == LAST_POS);

  // R10
  gap_nrz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitPos >= WORD_END) |-> !nrzData);

  always_comb begin
    if (rstN) begin
      // R9
      enables_excl_chk: assert (!(lineHi && lineLo));
      // R9
      rz_half_chk: assert (clk || !(lineHi || lineLo));
      // R11
      sync_place_chk: assert (syncN || (!clk && bitPos == SYNC_POS));
    end
  end
endmodule

bind arinc_word_tx arinc_word_chk #(
  .WORD_W(2 * HALF_W), .GAP_BITS(GAP_BITS), .SYNC_BIT(SYNC_BIT)
) uChk (
  .clk(clk), .rstN(rstN), .writeN(writeN), .hostSel(hostSel),
  .readyOut(readyOut), .lineHi(lineHi), .lineLo(lineLo),
  .nrzData(nrzData), .syncN(syncN), .bitPos(bitPos)
);

// File: tb/sim_arinc_word_tx.sv
module sim_arinc_word_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hostData = '0;
  logic hostSel = 1'b1;
  logic writeN = 1'b1;
  logic parityEn = 1'b0;
  logic readyOut, lineHi, lineLo, nrzData, syncN;

  arinc_word_tx u0 (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostSel(hostSel),
    .writeN(writeN), .parityEn(parityEn), .readyOut(readyOut),
    .lineHi(lineHi), .lineLo(lineLo), .nrzData(nrzData), .syncN(syncN)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // line monitor
  int rxCnt = 0, nullRun = 100, gotN = 0, startN = 0;
  int frameErr = 0, nrzBad = 0, rzBad = 0, syncCnt = 0, syncBad = 0;
  logic [31:0] rxWord = '0;
  logic prevRdy = 1'b1;
  logic [31:0] got [0:31];
  int gapBefore [0:31];
  logic rdyNow [0:31];
  logic rdyPrev [0:31];

  always @(posedge clk) begin
    #2;
    if (!rstN) begin
      rxCnt = 0;
      nullRun = 100;
    end else begin
      if (lineHi && lineLo) rzBad++;
      if (!syncN) syncBad++;
      if (lineHi || lineLo) begin
        if (nrzData !== lineHi) nrzBad++;
        if (rxCnt == 0) begin
          if (startN < 32) begin
            gapBefore[startN] = nullRun;
            rdyNow[startN] = readyOut;
            rdyPrev[startN] = prevRdy;
          end
          startN++;
        end
        if (rxCnt >= 32) frameErr++;
        else begin
          rxWord = {lineHi, rxWord[31:1]};
          rxCnt++;
        end
        nullRun = 0;
      end else begin
        if (nrzData) nrzBad++;
        if (rxCnt == 32) begin
          if (gotN < 32) got[gotN] = rxWord;
          gotN++;
        end else if (rxCnt != 0) frameErr++;
        rxCnt = 0;
        nullRun++;
      end
    end
    prevRdy = readyOut;
  end

  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (lineHi || lineLo) rzBad++;
      if (!syncN) begin
        syncCnt++;
        if (rxCnt != 8) syncBad++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [15:0] d);
    @(negedge clk);
    hostSel = sel;
    hostData = d;
    writeN = 1'b0;
    @(negedge clk);
    writeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitWord(input int n);
    int t = 0;
    while (gotN < n && t < 200) begin
      @(posedge clk);
      t++;
    end
    #3;
    chk(gotN >= n, "R4 word completion", gotN, n);
  endtask

  task automatic waitReady();
    int t = 0;
    while (!readyOut && t < 200) begin
      @(posedge clk);
      #2;
      t++;
    end
    chk(readyOut, "R5 ready return", readyOut, 1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // {parityEn, upper half, first half, expected serial word (bit 1 at [0])}
  localparam logic [64:0] VECS [0:6] = '{
    {1'b1, 16'h0000, 16'h0000, 32'h8000_0000},
    {1'b1, 16'hFFFF, 16'hFFFF, 32'h7FFF_FFFF},
    {1'b0, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF},
    {1'b1, 16'h0000, 16'h0001, 32'h0000_0001},
    {1'b0, 16'h8000, 16'h0000, 32'h8000_0000},
    {1'b1, 16'h8000, 16'h0003, 32'h8000_0003},
    {1'b0, 16'h0000, 16'hA5A5, 32'h0000_A5A5}
  };

  initial begin
    #100us;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int base;
    int lat;
    doReset();
    // reset state
    repeat (2) @(negedge clk);
    #2;
    chk(readyOut == 1'b1, "R8 ready after reset", readyOut, 1);
    chk(!lineHi && !lineLo && !nrzData, "R8 null after reset", {lineHi, lineLo, nrzData}, 0);
    chk(syncN == 1'b1, "R11 sync idle", syncN, 1);
    repeat (20) @(negedge clk);
    chk(gotN == 0 && startN == 0, "R8 continuous null while idle", startN, 0);

    // R12 upper half alone after reset: lower half stays cleared; R6 latency from idle
    parityEn = 1'b1;
    @(negedge clk);
    hostSel = 1'b0;
    hostData = 16'h1234;
    writeN = 1'b0;
    @(negedge clk);
    writeN = 1'b1;
    lat = 0;
    while (lat < 10) begin
      @(posedge clk);
      #2;
      lat++;
      if (lineHi || lineLo) break;
    end
    chk(lat == 2, "R6 first bit after idle load", lat, 2);
    waitWord(1);
    chk(got[0] == 32'h1234_0000, "R12 upper half without first half", got[0], 32'h1234_0000);

    // R1/R3 first half alone keeps ready high and sends nothing
    base = gotN;
    parityEn = 1'b0;
    repeat (8) @(negedge clk);
    hostWrite(1'b1, 16'h00F0);
    chk(readyOut == 1'b1, "R3 ready stays high after first half", readyOut, 1);
    repeat (10) @(negedge clk);
    chk(startN == base, "R3 no send on first half only", startN, base);
    hostWrite(1'b0, 16'h0001);
    chk(readyOut == 1'b0, "R3 ready low after upper half", readyOut, 0);
    waitWord(base + 1);
    chk(got[base] == 32'h0001_00F0, "R1 half ordering", got[base], 32'h0001_00F0);

    // table walk: R1 R2 R7
    for (int i = 0; i < 7; i++) begin
      base = gotN;
      parityEn = VECS[i][64];
      hostWrite(1'b1, VECS[i][47:32]);
      hostWrite(1'b0, VECS[i][63:48]);
      waitWord(base + 1);
      chk(got[base] == VECS[i][31:0], "R7 R2 table word", got[base], VECS[i][31:0]);
    end

    // back to back: R4 R5 R12
    repeat (10) @(negedge clk);
    base = gotN;
    parityEn = 1'b0;
    hostWrite(1'b1, 16'h5555);
    hostWrite(1'b0, 16'h2AAA);
    waitReady();
    hostWrite(1'b1, 16'h0F0F);
    hostWrite(1'b0, 16'h7000);
    chk(readyOut == 1'b0, "R3 ready low while staged", readyOut, 0);
    hostWrite(1'b1, 16'hFFFF);
    waitWord(base + 2);
    chk(got[base] == 32'h2AAA_5555, "R1 pipelined first word", got[base], 32'h2AAA_5555);
    chk(got[base+1] == 32'h7000_0F0F, "R12 write while not ready ignored", got[base+1], 32'h7000_0F0F);
    chk(gapBefore[base+1] == 4, "R4 gap length back to back", gapBefore[base+1], 4);
    chk(rdyPrev[base+1] == 1'b0 && rdyNow[base+1] == 1'b1, "R5 ready rises with bit 1",
        {rdyPrev[base+1], rdyNow[base+1]}, 2'b01);
    chk(rdyPrev[base] == 1'b0 && rdyNow[base] == 1'b1, "R6 ready rises with bit 1 from idle",
        {rdyPrev[base], rdyNow[base]}, 2'b01);

    // R8 reset during a word abandons it
    base = gotN;
    hostWrite(1'b1, 16'hFFFF);
    hostWrite(1'b0, 16'hFFFF);
    waitReady();
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    #2;
    chk(!lineHi && !lineLo && !nrzData, "R8 null at reset", {lineHi, lineLo, nrzData}, 0);
    chk(readyOut == 1'b1, "R8 ready at reset", readyOut, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (50) @(negedge clk);
    chk(gotN == base, "R8 aborted word not completed", gotN, base);

    chk(frameErr == 0, "R4 framing", frameErr, 0);
    chk(rzBad == 0, "R9 return to zero", rzBad, 0);
    chk(nrzBad == 0, "R10 nrz copy", nrzBad, 0);
    chk(syncBad == 0, "R11 sync position", syncBad, 0);
    chk(syncCnt == startN, "R11 one sync per word", syncCnt, startN);
    finishRun();
  end
endmodule